// File: doc/BRIEF.md
# Continuous Serial Configuration Link

The block keeps a remote configuration device in step with a local set of configuration fields. It runs without end. It sends a 60-bit configuration word LSB first over a data-out line and, in the same frame, collects a 43-bit status word from a data-in line. The link uses four pins: a serial clock made by dividing the system clock, a data-out line, a data-in line, and an active-low framing line. The framing line is low for one serial clock period before each transfer starts. Because frames follow one another with no idle time, the remote register always holds a copy of the local fields that is at most one frame old.

The configuration fields are sampled at the end of each frame and sent in the next frame. The most significant transmitted bit selects which of two converter channels the data byte is meant for. The block flips that bit by itself on every frame, so the two channels are served in turn. When a frame ends, the received status word is copied to the outputs as one unit. The converter sample it carries is filed under the channel number before the one the frame reports, because the remote side reports the channel it has already moved on to. While the received lock flag is set, an indicator output toggles every BLINK_HALF system cycles. This gives a 1 Hz flash when the parameter is set to half the clock frequency.

Top module: `cfg_link`

## Requirements
- R1: During reset, sclk, frame_n, sdo, rx_status, adc_slots and link_blink are all 0. The serial clock has a period of 2*SCLK_HALF system cycles, and its first half after reset is low.
- R2: A frame is 61 serial clock periods long. frame_n is low during the first period, which is the gap, and high during the other 60. sdo and frame_n change only on falling serial clock edges. Transmit bit i is driven during period i+1, starting from bit 0.
- R3: The transmit word layout is: bits 3:0 clock divider, 19:4 PLL control, 25:20 flag group (bit 20 PLL update, 21 L2 bypass, 22 L2 master count, 23 master count, 24 bus output enable, 25 header-Z enable), 29:26 high vector, 31:30 endianness, 35:32 CPU reset, 47:36 debug select, 50:48 interrupt mode, 58:51 DAC data, 59 DAC select.
- R4: The first frame after reset carries the default word: divider 0110, PLL control 0x1191, master count 1, CPU reset 1111, DAC select 0, and every other field 0.
- R5: The configuration inputs are sampled at the end of every frame and sent in the next frame. Frames repeat with no idle time between them.
- R6: The DAC select bit (bit 59) is 0 in the first frame and flips in every frame after that.
- R7: sdi is sampled on the rising serial clock edge of periods 1 to 43, and receive bit j comes from period j+1. The receive layout is: bit 0 PLL lock, 1 lock flag 0, 2 lock flag 1, 3 PLL updated, 7:4 reset request, 11:8 SMP/AMP, 15:12 wait-for-interrupt, 19:16 comms TX, 23:20 comms RX, 35:24 ADC data, 38:36 ADC channel, 42:39 version.
- R8: rx_status changes only at the end of a frame, when it takes the whole 43-bit word received in that frame.
- R9: At the end of a frame, the ADC data is written into slot (channel - 1) mod 8, which is adc_slots[12*s+11 : 12*s]. A reported channel of 0 therefore fills slot 7. The other slots keep their values.
- R10: link_blink is 0 whenever rx_status bit 0 is 0. When that bit rises, link_blink first rises BLINK_HALF cycles later, and after that it toggles every BLINK_HALF cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk_div | input | 4 | Clock divider field |
| cfg_pll_ctrl | input | 16 | PLL control field |
| cfg_flags | input | 6 | Single-bit flag group, in the order given in R3 |
| cfg_hi_vec | input | 4 | High vector field |
| cfg_endian | input | 2 | Endianness field |
| cfg_cpu_rst | input | 4 | CPU reset field |
| cfg_dbg_sel | input | 12 | Debug select field |
| cfg_int_mode | input | 3 | Interrupt mode field |
| cfg_dac_data | input | 8 | DAC data byte |
| sdi | input | 1 | Serial status data from the remote device |
| sclk | output | 1 | Serial clock |
| frame_n | output | 1 | Active-low framing line |
| sdo | output | 1 | Serial configuration data |
| rx_status | output | 43 | Last complete received status word |
| adc_slots | output | 96 | Eight 12-bit ADC slots |
| link_blink | output | 1 | Lock indicator |

## Verification
Four things happen on the same system cycle, the falling serial clock edge that ends a frame: the received word is committed, an ADC slot is written, the transmit shadow reloads from the inputs, and the DAC select bit flips. The bench changes every configuration field and the received word on every frame, so a mix-up among these updates shows up either in the next captured transmit word or in the committed status. The reported channel takes every value, including 0, so the write that wraps into slot 7 lands on the same cycle as a commit. All eight slots are compared after each frame, which shows that no other slot was disturbed.

// File: rtl/cfg_link_pkg.sv
package cfg_link_pkg;
  localparam int TX_W      = 60;
  localparam int RX_W      = 43;
  localparam int ADC_W     = 12;
  localparam int ADC_CH_W  = 3;
  localparam int ADC_SLOTS = 1 << ADC_CH_W;
  localparam int SLOTS     = TX_W + 1;

  // Builds the outgoing word, most significant field first
  function automatic logic [TX_W-1:0] pack_tx(
    input logic [3:0]  div,
    input logic [15:0] pll,
    input logic [5:0]  flags,
    input logic [3:0]  hvec,
    input logic [1:0]  endian,
    input logic [3:0]  crst,
    input logic [11:0] dbg,
    input logic [2:0]  imode,
    input logic [7:0]  ddata,
    input logic        dsel);
    return {dsel, ddata, imode, dbg, crst, endian, hvec, flags, pll, div};
  endfunction

  // The remote reports the channel it has already advanced to
  function automatic logic [ADC_CH_W-1:0] adc_slot_of(input logic [ADC_CH_W-1:0] ch);
    return ch - ADC_CH_W'(1);
  endfunction

  localparam logic [TX_W-1:0] TX_DEFAULT =
    pack_tx(4'b0110, 16'h1191, 6'b001000, 4'h0, 2'b00, 4'hF, 12'h000, 3'b000, 8'h00, 1'b0);
endpackage

// File: rtl/cfg_link_timer.sv
module cfg_link_timer #(
  parameter int SCLK_HALF = 4,
  parameter int NSLOTS    = 61
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic                      sclk,
  output logic                      rise_evt,
  output logic                      fall_evt,
  output logic                      frame_end,
  output logic [$clog2(NSLOTS)-1:0] slot
);
  localparam int CW = $clog2(SCLK_HALF + 1);
  localparam int SW = $clog2(NSLOTS);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = (cnt == CW'(SCLK_HALF - 1));
  assign rise_evt  = tick & ~sclk;
  assign fall_evt  = tick & sclk;
  assign frame_end = fall_evt & (slot == SW'(NSLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
      slot <= '0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
      if (sclk)
        slot <= frame_end ? '0 : slot + SW'(1);
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/cfg_link_tx.sv
module cfg_link_tx
  import cfg_link_pkg::*;
#(
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_evt,
  input  logic          frame_end,
  input  logic [SW-1:0] slot,
  input  logic [3:0]    cfg_clk_div,
  input  logic [15:0]   cfg_pll_ctrl,
  input  logic [5:0]    cfg_flags,
  input  logic [3:0]    cfg_hi_vec,
  input  logic [1:0]    cfg_endian,
  input  logic [3:0]    cfg_cpu_rst,
  input  logic [11:0]   cfg_dbg_sel,
  input  logic [2:0]    cfg_int_mode,
  input  logic [7:0]    cfg_dac_data,
  output logic          sdo,
  output logic          frame_n
);
  logic [TX_W-1:0] shadow;
  logic [SW-1:0]   nslot;

  assign nslot = frame_end ? '0 : slot + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= TX_DEFAULT;
      sdo     <= 1'b0;
      frame_n <= 1'b0;
    end else if (fall_evt) begin
      frame_n <= (nslot != '0);
      sdo     <= (nslot == '0) ? 1'b0 : shadow[nslot - SW'(1)];
      if (frame_end)
        shadow <= pack_tx(cfg_clk_div, cfg_pll_ctrl, cfg_flags, cfg_hi_vec, cfg_endian,
                          cfg_cpu_rst, cfg_dbg_sel, cfg_int_mode, cfg_dac_data,
                          ~shadow[TX_W-1]);
    end
  end
endmodule

// File: rtl/cfg_link_rx.sv
module cfg_link_rx
  import cfg_link_pkg::*;
#(
  parameter int SW = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rise_evt,
  input  logic                       frame_end,
  input  logic [SW-1:0]              slot,
  input  logic                       sdi,
  output logic [RX_W-1:0]            rx_status,
  output logic [ADC_SLOTS*ADC_W-1:0] adc_slots
);
  logic [RX_W-1:0]     acc;
  logic [ADC_CH_W-1:0] wr_slot;
  logic                in_window;

  assign in_window = (slot != '0) && (slot <= SW'(RX_W));
  assign wr_slot   = adc_slot_of(acc[38:36]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      rx_status <= '0;
    end else begin
      if (rise_evt && in_window)
        acc[slot - SW'(1)] <= sdi;
      if (frame_end)
        rx_status <= acc;
    end
  end

  for (genvar s = 0; s < ADC_SLOTS; s++) begin : g_slot
    logic [ADC_W-1:0] mem;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem <= '0;
      else if (frame_end && (wr_slot == ADC_CH_W'(s)))
        mem <= acc[35:24];
    end
    assign adc_slots[s*ADC_W +: ADC_W] = mem;
  end
endmodule

// File: rtl/cfg_link_blink.sv
module cfg_link_blink #(
  parameter int BLINK_HALF = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic locked,
  output logic blink
);
  localparam int BW = $clog2(BLINK_HALF + 1);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      blink <= 1'b0;
    end else if (!locked) begin
      cnt   <= '0;
      blink <= 1'b0;
    end else if (cnt == BW'(BLINK_HALF - 1)) begin
      cnt   <= '0;
      blink <= ~blink;
    end else begin
      cnt <= cnt + BW'(1);
    end
  end
endmodule

// File: rtl/cfg_link.sv
module cfg_link
  import cfg_link_pkg::*;
#(
  parameter int SCLK_HALF  = 4,
  parameter int BLINK_HALF = 50_000_000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   cfg_clk_div,
  input  logic [15:0]  cfg_pll_ctrl,
  input  logic [5:0]   cfg_flags,
  input  logic [3:0]   cfg_hi_vec,
  input  logic [1:0]   cfg_endian,
  input  logic [3:0]   cfg_cpu_rst,
  input  logic [11:0]  cfg_dbg_sel,
  input  logic [2:0]   cfg_int_mode,
  input  logic [7:0]   cfg_dac_data,
  input  logic         sdi,
  output logic         sclk,
  output logic         frame_n,
  output logic         sdo,
  output logic [42:0]  rx_status,
  output logic [95:0]  adc_slots,
  output logic         link_blink
);
  localparam int SW = $clog2(SLOTS);

  logic          rise_evt;
  logic          fall_evt;
  logic          frame_end;
  logic [SW-1:0] slot;

  cfg_link_timer #(.SCLK_HALF(SCLK_HALF), .NSLOTS(SLOTS)) u_timer (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .frame_end(frame_end), .slot(slot));

  cfg_link_tx #(.SW(SW)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .frame_end(frame_end), .slot(slot),
    .cfg_clk_div(cfg_clk_div), .cfg_pll_ctrl(cfg_pll_ctrl), .cfg_flags(cfg_flags),
    .cfg_hi_vec(cfg_hi_vec), .cfg_endian(cfg_endian), .cfg_cpu_rst(cfg_cpu_rst),
    .cfg_dbg_sel(cfg_dbg_sel), .cfg_int_mode(cfg_int_mode), .cfg_dac_data(cfg_dac_data),
    .sdo(sdo), .frame_n(frame_n));

  cfg_link_rx #(.SW(SW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .frame_end(frame_end), .slot(slot),
    .sdi(sdi), .rx_status(rx_status), .adc_slots(adc_slots));

  cfg_link_blink #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .locked(rx_status[0]), .blink(link_blink));
endmodule

// File: rtl/cfg_link_chk.sv
module cfg_link_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk,
  input logic        frame_n,
  input logic        sdo,
  input logic        rise_evt,
  input logic        fall_evt,
  input logic        frame_end,
  input logic [42:0] rx_status,
  input logic        link_blink
);
  // R1
  sclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) rise_evt |=> sclk);
  // R1
  sclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) fall_evt |=> !sclk);
  // R2
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !fall_evt |=> $stable(sdo));
  // R2
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !fall_evt |=> $stable(frame_n));
  // R2
  gap_start_chk: assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> !frame_n);
  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !frame_end |=> $stable(rx_status));
  // R10
  blink_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !rx_status[0] |=> !link_blink);
endmodule

bind cfg_link cfg_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_n(frame_n), .sdo(sdo),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .frame_end(frame_end),
  .rx_status(rx_status), .link_blink(link_blink));

// File: tb/cfg_link_bench.sv
module cfg_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHALF      = 2;
  localparam int BHALF      = 16;
  localparam int NFRAMES    = 14;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_clk_div = '0;
  logic [15:0] cfg_pll_ctrl = '0;
  logic [5:0] cfg_flags = '0;
  logic [3:0] cfg_hi_vec = '0;
  logic [1:0] cfg_endian = '0;
  logic [3:0] cfg_cpu_rst = '0;
  logic [11:0] cfg_dbg_sel = '0;
  logic [2:0] cfg_int_mode = '0;
  logic [7:0] cfg_dac_data = '0;
  logic sdi = 1'b0;
  logic sclk, frame_n, sdo, link_blink;
  logic [42:0] rx_status;
  logic [95:0] adc_slots;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int mon_frames = 0;

  logic [59:0] tx_q[$];
  logic [42:0] rx_q[$];
  logic [11:0] slot_mdl[8];

  cfg_link #(.SCLK_HALF(SHALF), .BLINK_HALF(BHALF)) u_cfg_link (
    .clk(clk), .rst_n(rst_n), .cfg_clk_div(cfg_clk_div), .cfg_pll_ctrl(cfg_pll_ctrl),
    .cfg_flags(cfg_flags), .cfg_hi_vec(cfg_hi_vec), .cfg_endian(cfg_endian),
    .cfg_cpu_rst(cfg_cpu_rst), .cfg_dbg_sel(cfg_dbg_sel), .cfg_int_mode(cfg_int_mode),
    .cfg_dac_data(cfg_dac_data), .sdi(sdi), .sclk(sclk), .frame_n(frame_n), .sdo(sdo),
    .rx_status(rx_status), .adc_slots(adc_slots), .link_blink(link_blink));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench's own view of the transmit layout (R3)
  function automatic logic [59:0] build_tx(input logic [3:0] d, input logic [15:0] p,
      input logic [5:0] f, input logic [3:0] h, input logic [1:0] e, input logic [3:0] c,
      input logic [11:0] g, input logic [2:0] m, input logic [7:0] a, input logic s);
    logic [59:0] v;
    v = '0;
    v[59] = s;        v[58:51] = a;  v[50:48] = m;  v[47:36] = g;
    v[35:32] = c;     v[31:30] = e;  v[29:26] = h;  v[25:20] = f;
    v[19:4] = p;      v[3:0] = d;
    return v;
  endfunction

  function automatic logic [42:0] rx_word(input int k);
    logic lock;
    lock = (k >= 3) && (k < 8);
    return {4'(k + 5), 3'(k), 12'(12'h0A5 + k * 37), 23'((k * 23'h01357) ^ 23'h2AAAA), lock};
  endfunction

  // Driver: picks stimulus per frame and pushes the expected items
  task automatic drive_frame(input int k, output logic [42:0] w);
    cfg_clk_div  = 4'(k * 3 + 1);
    cfg_pll_ctrl = 16'(16'hA55A ^ (k * 16'h0123));
    cfg_flags    = 6'(k * 11);
    cfg_hi_vec   = 4'(~k);
    cfg_endian   = 2'(k);
    cfg_cpu_rst  = 4'(k * 5);
    cfg_dbg_sel  = 12'(12'hC3C + k);
    cfg_int_mode = 3'(k + 2);
    cfg_dac_data = 8'(k * 29);
    tx_q.push_back(build_tx(cfg_clk_div, cfg_pll_ctrl, cfg_flags, cfg_hi_vec, cfg_endian,
                            cfg_cpu_rst, cfg_dbg_sel, cfg_int_mode, cfg_dac_data, 1'((k + 1) & 1)));
    w = rx_word(k);
    rx_q.push_back(w);
  endtask

  initial begin : driver
    int k = 0;
    int bi = 0;
    logic [42:0] w_cur = '0;
    // R4: frame 0 is the default word
    tx_q.push_back(build_tx(4'b0110, 16'h1191, 6'b001000, 4'h0, 2'b00, 4'hF, 12'h000, 3'b000, 8'h00, 1'b0));
    wait (rst_n);
    forever begin
      @(posedge sclk);
      if (!frame_n) begin
        drive_frame(k, w_cur);
        k++;
        bi = 0;
        #1 sdi = w_cur[0];
      end else begin
        bi++;
        #1 sdi = (bi < 43) ? w_cur[bi] : 1'b0;
      end
    end
  end

  initial begin : monitor
    logic [59:0] cap = '0;
    int nb = 0;
    wait (rst_n);
    forever begin
      @(posedge sclk);
      if (!frame_n) begin
        if (mon_frames > 0) begin
          logic [59:0] exp_tx;
          logic [42:0] exp_rx;
          logic [2:0] s;
          logic [95:0] exp_slots;
          exp_tx = tx_q.pop_front();
          exp_rx = rx_q.pop_front();
          check(nb == 60, "R2 data periods per frame", 96'(nb), 96'd60);
          if (mon_frames == 1) check(cap == exp_tx, "R4 default frame", 96'(cap), 96'(exp_tx));
          else check(cap[58:0] == exp_tx[58:0], "R3/R5 fields", 96'(cap), 96'(exp_tx));
          check(cap[59] == exp_tx[59], "R6 dac select", 96'(cap[59]), 96'(exp_tx[59]));
          check(rx_status == exp_rx, "R7/R8 status commit", 96'(rx_status), 96'(exp_rx));
          s = exp_rx[38:36] - 3'd1;
          slot_mdl[s] = exp_rx[35:24];
          for (int i = 0; i < 8; i++) exp_slots[i*12 +: 12] = slot_mdl[i];
          check(adc_slots == exp_slots, "R9 adc slots", adc_slots, exp_slots);
          if (!exp_rx[0]) check(link_blink == 1'b0, "R10 blink off", 96'(link_blink), 96'd0);
        end
        nb = 0;
        mon_frames++;
      end else begin
        if (nb < 60) cap[nb] = sdo;
        nb++;
      end
    end
  end

  initial begin : blink_mon
    int t0 = 0;
    bit armed = 0;
    logic pl = 0, pb = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (rx_status[0] && !pl) begin t0 = cyc; armed = 1; end
      if (link_blink && !pb && armed) begin
        check(cyc - t0 == BHALF, "R10 blink delay", 96'(cyc - t0), 96'(BHALF));
        armed = 0;
      end
      pl = rx_status[0];
      pb = link_blink;
    end
  end

  initial begin : sclk_mon
    int tr = 0;
    bit seen = 0;
    wait (rst_n);
    repeat (3) begin
      @(posedge sclk);
      @(negedge clk);
      if (seen) check(cyc - tr == 2 * SHALF, "R1 sclk period", 96'(cyc - tr), 96'(2 * SHALF));
      tr = cyc;
      seen = 1;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) slot_mdl[i] = '0;
    repeat (4) @(negedge clk);
    check({sclk, frame_n, sdo, link_blink} == 4'b0, "R1 reset pins",
          96'({sclk, frame_n, sdo, link_blink}), 96'd0);
    check(rx_status == '0 && adc_slots == '0, "R1 reset status", 96'(rx_status), 96'd0);
    rst_n = 1'b1;
    wait (mon_frames > NFRAMES || cyc >= WATCHDOG);
    if (cyc >= WATCHDOG) check(1'b0, "watchdog", 96'(cyc), 96'(WATCHDOG));
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule